// File: doc/BRIEF.md
# Stack Transfer Sequencer

This block moves 16-bit register pairs between an 8-bit CPU datapath and the stack in a byte-wide memory. It owns the stack pointer and runs three operations: push a pair onto the stack, pop a word into a pair, and swap a pair with the word at the top of the stack. The caller picks the operation with an operation code and picks the pair with a 3-bit select code. The caller also supplies that pair's current value on `pair_in` in the same cycle as `start`.

Every operation moves one byte per clock. Words are little-endian: the low byte is at the stack pointer and the high byte one address above it. During an operation `busy` is high, and `done` pulses in its last cycle. When a pop or an exchange writes a value back to a pair, `pair_we` is asserted together with the value and the destination code. The register file itself is outside the block and is reached only through these ports. Flags are only ever loaded by a pop into AF, which `flags_we` signals.

Top module: `stack_xfer_unit`

## Requirements
- R1: After a synchronous active-low reset, the stack pointer equals `SP_RESET`, and `busy`, `done`, `mem_we`, `mem_re`, `pair_we` and `flags_we` are all low.
- R2: Push (op code 0) decrements the stack pointer by two. It then writes the low byte of `pair_in` to the new pointer and the high byte to the new pointer plus one. This takes two busy cycles.
- R3: Pop (op code 1) reads the low byte at the pointer and the high byte at the pointer plus one. In the second busy cycle it presents the word on `pair_out` with `pair_we` high for exactly one cycle. The pointer is then two higher.
- R4: Exchange (op code 2) reads both bytes at the pointer before it writes either byte. It then writes `pair_in` back to the same two addresses and returns the old word on `pair_out` with `pair_we`. It takes four busy cycles and leaves the pointer unchanged.
- R5: Select codes are 0 AF, 1 BC, 2 DE, 3 HL, 4 IX and 5 IY. For push and pop, codes 6 and 7 are ignored: no busy, no memory access, and the pointer is unchanged.
- R6: An exchange with any select code other than 3, 4 or 5 is ignored in the same way.
- R7: `flags_we` is high only in the `pair_we` cycle of a pop with select code 0.
- R8: The stack pointer and the byte address wrap modulo 65536. For example, a push at pointer 0x0001 writes to 0xFFFF and 0x0000.
- R9: A `start` that arrives while `busy` is high is ignored.
- R10: Op code 3 is ignored: no busy, no memory access, and the pointer is unchanged.
- R11: `done` is high for one cycle, and only in the last busy cycle. `mem_we` and `mem_re` are never high together, and neither is high outside `busy`.
- R12: `pair_sel` equals the select code that was accepted, whenever `pair_we` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to begin an operation |
| op | input | 2 | 0 push, 1 pop, 2 exchange, 3 none |
| rsel | input | 3 | Register pair select code |
| pair_in | input | 16 | Current value of the selected pair |
| mem_rdata | input | 8 | Read data, valid in the same cycle as the address |
| mem_addr | output | AW | Byte address |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Write data |
| pair_we | output | 1 | Write strobe for the destination pair |
| pair_sel | output | 3 | Destination pair code |
| pair_out | output | 16 | Word for the destination pair |
| flags_we | output | 1 | Flags load strobe (pop into AF) |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | Last cycle of an operation |
| sp_out | output | AW | Current stack pointer |

## Verification
The embedded properties take two things for granted. Memory read data must be valid within the same cycle as the address. The caller must hold `pair_in` valid in the `start` cycle. The bench meets both conditions with a combinational array model and by driving `pair_in` together with `start` on the falling edge. The bench sweeps every op code against every select code over several rounds. It starts from an odd pointer, so pushes and pops wrap across address 0xFFFF/0x0000. A separate case holds `start` high through a push to confirm that a request made while busy is dropped.

// File: rtl/stk_pkg.sv
// Shared types for the stack transfer sequencer.
// Assumes 8-bit memory bytes and 16-bit register pairs.
package stk_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    typedef enum logic [1:0] {
        OP_PUSH = 2'd0,
        OP_POP  = 2'd1,
        OP_XCHG = 2'd2,
        OP_NONE = 2'd3
    } stk_op_e;

    typedef enum logic [2:0] {
        RP_AF = 3'd0,
        RP_BC = 3'd1,
        RP_DE = 3'd2,
        RP_HL = 3'd3,
        RP_IX = 3'd4,
        RP_IY = 3'd5
    } stk_rp_e;

    // Legal operation/pair combinations (R5, R6, R10).
    function automatic logic op_ok(input logic [1:0] op, input logic [2:0] sel);
        case (op)
            OP_PUSH, OP_POP: op_ok = (sel <= 3'd5);
            OP_XCHG:         op_ok = (sel == 3'd3) || (sel == 3'd4) || (sel == 3'd5);
            default:         op_ok = 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/stk_pointer.sv
// Stack pointer register: steps by two in either direction and wraps
// modulo 2**AW. Assumes the sequencer never requests both steps at once.
module stk_pointer #(
    parameter int          AW       = 16,
    parameter logic [AW-1:0] SP_RESET = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dec2,
    input  logic          inc2,
    output logic [AW-1:0] sp
);
    localparam logic [AW-1:0] STEP = AW'(2);

    logic [AW-1:0] sp_q;

    // Hold, decrement or increment the pointer.
    always_ff @(posedge clk) begin
        if (!rst_n)    sp_q <= SP_RESET;
        else if (dec2) sp_q <= sp_q - STEP;
        else if (inc2) sp_q <= sp_q + STEP;
    end

    assign sp = sp_q;

    p_no_dual_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec2 && inc2));

    p_sp_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_q != $past(sp_q)) |->
            ((sp_q == AW'($past(sp_q) + STEP)) || (sp_q == AW'($past(sp_q) - STEP))));
endmodule

// File: rtl/stk_addr.sv
// Byte address generator: the pointer, or the pointer plus one for the
// high byte. Wraps modulo 2**AW.
module stk_addr #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] sp,
    input  logic          hi,
    output logic [AW-1:0] addr
);
    // Add the byte offset.
    always_comb addr = sp + {{(AW-1){1'b0}}, hi};
endmodule

// File: rtl/stk_seq.sv
// Operation sequencer: one memory byte per cycle. A push writes low then high.
// A pop reads low then high. An exchange reads both bytes and then writes both.
// Assumes mem_rdata is valid in the same cycle as the address, and pair_in
// is valid in the start cycle.
module stk_seq
    import stk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic [2:0]        sel,
    input  logic [WORD_W-1:0] pair_in,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              byte_hi,
    output logic              mem_re,
    output logic              mem_we,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              pair_we,
    output logic [2:0]        pair_sel,
    output logic [WORD_W-1:0] pair_wdata,
    output logic              flags_we,
    output logic              busy,
    output logic              done,
    output logic              sp_dec2,
    output logic              sp_inc2
);
    typedef enum logic [3:0] {
        S_IDLE, S_PUSH_LO, S_PUSH_HI, S_POP_LO, S_POP_HI,
        S_XR_LO, S_XR_HI, S_XW_LO, S_XW_HI
    } seq_st_e;

    seq_st_e           state, nxt;
    logic [2:0]        sel_q;
    logic [WORD_W-1:0] word_q;
    logic [BYTE_W-1:0] lo_q, hi_q;
    logic              accept;

    assign accept = (state == S_IDLE) && start && op_ok(op, sel);

    // Next-state selection.
    always_comb begin
        nxt = state;
        case (state)
            S_IDLE: if (accept) begin
                case (op)
                    OP_PUSH: nxt = S_PUSH_LO;
                    OP_POP:  nxt = S_POP_LO;
                    default: nxt = S_XR_LO;
                endcase
            end
            S_PUSH_LO: nxt = S_PUSH_HI;
            S_POP_LO:  nxt = S_POP_HI;
            S_XR_LO:   nxt = S_XR_HI;
            S_XR_HI:   nxt = S_XW_LO;
            S_XW_LO:   nxt = S_XW_HI;
            default:   nxt = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Capture the operands at accept and the bytes read from memory.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            word_q <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
        end else begin
            if (accept) begin
                sel_q  <= sel;
                word_q <= pair_in;
            end
            if (state == S_POP_LO || state == S_XR_LO) lo_q <= mem_rdata;
            if (state == S_XR_HI)                      hi_q <= mem_rdata;
        end
    end

    // Output decode from the state.
    always_comb begin
        byte_hi    = (state == S_PUSH_HI) || (state == S_POP_HI) ||
                     (state == S_XR_HI)   || (state == S_XW_HI);
        mem_we     = (state == S_PUSH_LO) || (state == S_PUSH_HI) ||
                     (state == S_XW_LO)   || (state == S_XW_HI);
        mem_re     = (state == S_POP_LO)  || (state == S_POP_HI) ||
                     (state == S_XR_LO)   || (state == S_XR_HI);
        mem_wdata  = byte_hi ? word_q[WORD_W-1:BYTE_W] : word_q[BYTE_W-1:0];
        pair_we    = (state == S_POP_HI) || (state == S_XW_HI);
        pair_wdata = (state == S_POP_HI) ? {mem_rdata, lo_q} : {hi_q, lo_q};
        pair_sel   = sel_q;
        flags_we   = (state == S_POP_HI) && (sel_q == RP_AF);
        busy       = (state != S_IDLE);
        done       = (state == S_PUSH_HI) || (state == S_POP_HI) || (state == S_XW_HI);
        sp_dec2    = accept && (op == OP_PUSH);
        sp_inc2    = (state == S_POP_HI);
    end

    p_done_in_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_mem_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> (busy && !(mem_we && mem_re)));

    p_pair_we_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pair_we |-> done);

    p_flags_af_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flags_we |-> (pair_we && pair_sel == 3'd0));

    p_ignore_bad_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !op_ok(op, sel)) |=> !busy);

    p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> (busy && $stable(pair_sel)));
endmodule

// File: rtl/stack_xfer_unit.sv
// Stack transfer sequencer top: stack pointer, byte address generator and
// operation sequencer. Assumes a byte memory with read data in the same cycle.
module stack_xfer_unit
    import stk_pkg::*;
#(
    parameter int            AW       = 16,
    parameter logic [AW-1:0] SP_RESET = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic [2:0]        rsel,
    input  logic [15:0]       pair_in,
    input  logic [7:0]        mem_rdata,
    output logic [AW-1:0]     mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [7:0]        mem_wdata,
    output logic              pair_we,
    output logic [2:0]        pair_sel,
    output logic [15:0]       pair_out,
    output logic              flags_we,
    output logic              busy,
    output logic              done,
    output logic [AW-1:0]     sp_out
);
    logic          byte_hi, sp_dec2, sp_inc2;
    logic [AW-1:0] sp;

    stk_pointer #(.AW(AW), .SP_RESET(SP_RESET)) u_sp (
        .clk(clk), .rst_n(rst_n), .dec2(sp_dec2), .inc2(sp_inc2), .sp(sp)
    );

    stk_addr #(.AW(AW)) u_addr (.sp(sp), .hi(byte_hi), .addr(mem_addr));

    stk_seq u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .sel(rsel),
        .pair_in(pair_in), .mem_rdata(mem_rdata), .byte_hi(byte_hi),
        .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .pair_we(pair_we), .pair_sel(pair_sel), .pair_wdata(pair_out),
        .flags_we(flags_we), .busy(busy), .done(done),
        .sp_dec2(sp_dec2), .sp_inc2(sp_inc2)
    );

    assign sp_out = sp;

    p_sp_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && !mem_re && mem_we) |=> $stable(sp));

    p_sp_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(start && op == 2'd0)) |=> $stable(sp));
endmodule

// File: tb/sim_stack_xfer_unit.sv
module sim_stack_xfer_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'd3;
    logic [2:0]  rsel = 3'd0;
    logic [15:0] pair_in = 16'h0;
    logic [7:0]  mem_rdata;
    logic [15:0] mem_addr, pair_out, sp_out;
    logic        mem_re, mem_we, pair_we, flags_we, busy, done;
    logic [7:0]  mem_wdata;
    logic [2:0]  pair_sel;

    logic [7:0]  ram   [0:65535];
    logic [7:0]  ref_m [0:65535];
    logic [15:0] exp_sp;
    int          n_chk = 0, n_fail = 0, cyc_total = 0;

    // Captured by run_op.
    int          c_cyc, c_we, c_re, c_pw, c_fw, c_done, c_done_idx, c_last_re, c_first_we;
    logic [15:0] c_pw_data;
    logic [2:0]  c_pw_sel;

    stack_xfer_unit #(.AW(16), .SP_RESET(16'h0001)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .rsel(rsel),
        .pair_in(pair_in), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
        .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .pair_we(pair_we), .pair_sel(pair_sel), .pair_out(pair_out),
        .flags_we(flags_we), .busy(busy), .done(done), .sp_out(sp_out)
    );

    always #10 clk = ~clk;

    assign mem_rdata = ram[mem_addr];
    always @(posedge clk) if (mem_we) ram[mem_addr] <= mem_wdata;

    always @(posedge clk) begin
        cyc_total <= cyc_total + 1;
        if (cyc_total > 100000) begin
            $display("FAIL watchdog: actual=%0d cycles expected<100000", cyc_total);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail + 1);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [1:0] o, input logic [2:0] s, input logic [15:0] w);
        @(negedge clk);
        start = 1'b1; op = o; rsel = s; pair_in = w;
        @(negedge clk);
        start = 1'b0; op = 2'd3;
        c_cyc = 0; c_we = 0; c_re = 0; c_pw = 0; c_fw = 0; c_done = 0;
        c_done_idx = -1; c_last_re = -1; c_first_we = 99;
        c_pw_data = '0; c_pw_sel = '0;
        while (busy && c_cyc < 16) begin
            if (mem_we) begin c_we++; if (c_first_we == 99) c_first_we = c_cyc; end
            if (mem_re) begin c_re++; c_last_re = c_cyc; end
            if (pair_we) begin c_pw++; c_pw_data = pair_out; c_pw_sel = pair_sel; end
            if (flags_we) c_fw++;
            if (done) begin c_done++; c_done_idx = c_cyc; end
            c_cyc++;
            @(negedge clk);
        end
    endtask

    initial begin
        for (int i = 0; i < 65536; i++) begin
            ram[i]   = 8'(i ^ (i >> 8) ^ 8'h5A);
            ref_m[i] = 8'(i ^ (i >> 8) ^ 8'h5A);
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(sp_out == 16'h0001, "R1 sp", 32'(sp_out), 32'h1);
        chk(!busy && !done, "R1 busy/done", {busy, done}, 0);
        chk(!mem_we && !mem_re && !pair_we && !flags_we, "R1 strobes",
            {mem_we, mem_re, pair_we, flags_we}, 0);
        rst_n = 1'b1;
        exp_sp = 16'h0001;

        for (int r = 0; r < 4; r++) begin
            for (int o = 0; o < 4; o++) begin
                for (int s = 0; s < 8; s++) begin
                    logic [15:0] w, a0, a1, old;
                    bit valid;
                    w = 16'(16'h1357 * (r * 32 + o * 8 + s + 1));
                    valid = ((o == 0 || o == 1) && s <= 5) || (o == 2 && s >= 3 && s <= 5);
                    run_op(2'(o), 3'(s), w);
                    if (!valid) begin
                        // R5 R6 R10: ignored codes
                        chk(c_cyc == 0 && c_we == 0 && c_re == 0, "R5_R6_R10 ignored", c_cyc, 0);
                        chk(sp_out == exp_sp, "R5_R6_R10 sp", 32'(sp_out), 32'(exp_sp));
                    end else if (o == 0) begin
                        exp_sp = exp_sp - 16'd2;
                        a0 = exp_sp; a1 = exp_sp + 16'd1;
                        ref_m[a0] = w[7:0]; ref_m[a1] = w[15:8];
                        chk(c_cyc == 2 && c_we == 2, "R2 cycles", c_cyc, 2);
                        chk(sp_out == exp_sp, "R2_R8 sp", 32'(sp_out), 32'(exp_sp));
                        chk(ram[a0] == w[7:0], "R2_R8 low byte", 32'(ram[a0]), 32'(w[7:0]));
                        chk(ram[a1] == w[15:8], "R2_R8 high byte", 32'(ram[a1]), 32'(w[15:8]));
                        chk(c_pw == 0 && c_fw == 0, "R7 push no flags", c_fw, 0);
                    end else if (o == 1) begin
                        a0 = exp_sp; a1 = exp_sp + 16'd1;
                        old = {ref_m[a1], ref_m[a0]};
                        exp_sp = exp_sp + 16'd2;
                        chk(c_cyc == 2 && c_pw == 1 && c_re == 2, "R3 cycles", c_cyc, 2);
                        chk(c_pw_data == old, "R3 data", 32'(c_pw_data), 32'(old));
                        chk(sp_out == exp_sp, "R3_R8 sp", 32'(sp_out), 32'(exp_sp));
                        chk(c_fw == (s == 0 ? 1 : 0), "R7 flags", c_fw, (s == 0 ? 1 : 0));
                        chk(c_pw_sel == 3'(s), "R12 sel", 32'(c_pw_sel), s);
                    end else begin
                        a0 = exp_sp; a1 = exp_sp + 16'd1;
                        old = {ref_m[a1], ref_m[a0]};
                        ref_m[a0] = w[7:0]; ref_m[a1] = w[15:8];
                        chk(c_cyc == 4 && c_we == 2 && c_re == 2, "R4 cycles", c_cyc, 4);
                        chk(c_last_re < c_first_we, "R4 read first", c_last_re, c_first_we);
                        chk(c_pw_data == old, "R4 old word", 32'(c_pw_data), 32'(old));
                        chk(ram[a0] == w[7:0] && ram[a1] == w[15:8], "R4 mem",
                            {ram[a1], ram[a0]}, 32'(w));
                        chk(sp_out == exp_sp, "R4 sp", 32'(sp_out), 32'(exp_sp));
                        chk(c_fw == 0 && c_pw_sel == 3'(s), "R7_R12 xchg", c_fw, 0);
                    end
                    if (valid)
                        chk(c_done == 1 && c_done_idx == c_cyc - 1, "R11 done", c_done_idx, c_cyc - 1);
                end
            end
        end

        // R9: start held during a push must not launch a second operation
        @(negedge clk);
        start = 1'b1; op = 2'd0; rsel = 3'd1; pair_in = 16'hBEEF;
        @(negedge clk);
        op = 2'd1; rsel = 3'd2;
        @(negedge clk);
        @(negedge clk);
        start = 1'b0; op = 2'd3;
        exp_sp = exp_sp - 16'd2;
        chk(!busy, "R9 idle after push", busy, 0);
        chk(sp_out == exp_sp, "R9 sp", 32'(sp_out), 32'(exp_sp));
        chk(ram[exp_sp] == 8'hEF, "R9 data", 32'(ram[exp_sp]), 32'hEF);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule